// File: doc/BRIEF.md
# AES Key-Absorbing Memory Fingerprinter

This block reduces a large read-write working memory to a 512-bit fingerprint. The memory contents are not encrypted. They are fed in as round keys. Four independent 128-bit lanes each start from a fixed constant. Every 512-bit memory word that streams in drives one AES encryption round in every lane, and lane k uses bits [128k+127:128k] of the word as its round key. Over the whole memory, each lane therefore runs through one very long key schedule made of the memory itself.

After the programmed number of words has been absorbed, each lane runs two more rounds with fixed keys. These rounds spread every absorbed bit across the whole lane. The four lane states, concatenated, form the fingerprint, and a downstream cryptographic hash takes it from there. A controller starts a job with a word count, accepts words with a valid/ready handshake, and raises a one-cycle completion pulse when the fingerprint is ready.

The word count can be programmed, so a small memory can stand in for the full-size one.

Top module: `fpabs_absorber`

## Requirements
- R1: While reset is held and after it is released, `fp_o` is zero and `done_o`, `busy_o` and `in_ready_o` are low.
- R2: A start accepted with a non-zero count raises `in_ready_o` from the next cycle. `in_ready_o` stays high until exactly that many words have been taken (`in_valid_i` and `in_ready_o` both high at a clock edge). It is low whenever the block is idle.
- R3: Each lane round works on a 128-bit state. Byte i is bits [8i+7:8i], at row i mod 4 and column i div 4. A round applies, in order: the AES S-box to each byte; a left rotation of row r by r columns; the AES MixColumns matrix on each column over GF(2^8) with polynomial 0x11B; and an XOR with the round key. Each taken word advances every lane by one such round, and lane k is keyed by word bits [128k+127:128k].
- R4: A word offered while `in_valid_i` is low, or with gaps between valid words, does not change the result. Only taken words are absorbed.
- R5: After the last word is taken, each lane runs one round keyed by parameter `FIN_KEY_A` and then one round keyed by `FIN_KEY_B`. `done_o` is high in the third cycle after the clock edge that took the last word.
- R6: `done_o` is high for exactly one cycle. `fp_o` holds the final value from that cycle until the next start is accepted.
- R7: A start with a count of zero raises no `in_ready_o`. It applies only the two finishing rounds to the initial lane states, and `done_o` is high in the third cycle after the start edge.
- R8: A start issued while `busy_o` is high is ignored. The running job keeps its count and its result.
- R9: The lane states are set to slices of parameter `INIT_STATE` (lane k from bits [128k+127:128k]) when a start is accepted. Lane k of `fp_o` depends only on slice k of the absorbed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a job; accepted only while idle |
| len_i | input | LEN_W | Number of words to absorb, sampled at start |
| in_data_i | input | 128*LANES | Memory word; lane k uses slice k |
| in_valid_i | input | 1 | Memory word is present |
| in_ready_o | output | 1 | Block will take the word at this edge |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse: fingerprint is final |
| fp_o | output | 128*LANES | Fingerprint, lane k in slice k |

## Verification
Word streams from one to thirty-three words are compared against an independent lane model in the bench. That model builds its S-box from a generator walk rather than by field inversion, and uses the shared-XOR form of column mixing. A mismatch in substitution, row rotation, mixing, key slicing or the finishing keys shows up in the fingerprint. Streams with idle gaps, or with a stray start part-way through, must give the same fingerprint as contiguous streams. This separates handshake faults from arithmetic faults. A zero-length job isolates the finishing rounds. A stream that differs only in one lane's key slice must change that lane alone, which exposes any cross-lane wiring.

// File: rtl/fpabs_pkg.sv
package fpabs_pkg;

  localparam int BLK_W = 128;
  localparam int BYTES = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ABSORB,
    PH_FIN_A,
    PH_FIN_B
  } phase_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_x2(t);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return 8'((a << n) | (a >> (8 - n)));
  endfunction

  // S-box: inverse as a^254 (0 maps to 0), then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // byte substitution fused with row rotation; byte i sits at row i%4, column i/4
  function automatic blk_t sub_shift(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[8*(r+4*c) +: 8] = sbox(s[8*(r+4*((c+r)%4)) +: 8]);
      end
    end
    return o;
  endfunction

  function automatic blk_t mix_cols(input blk_t s);
    blk_t o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[8*(4*c)   +: 8];
      a1 = s[8*(4*c+1) +: 8];
      a2 = s[8*(4*c+2) +: 8];
      a3 = s[8*(4*c+3) +: 8];
      o[8*(4*c)   +: 8] = gf_mul(a0, 8'h02) ^ gf_mul(a1, 8'h03) ^ a2 ^ a3;
      o[8*(4*c+1) +: 8] = a0 ^ gf_mul(a1, 8'h02) ^ gf_mul(a2, 8'h03) ^ a3;
      o[8*(4*c+2) +: 8] = a0 ^ a1 ^ gf_mul(a2, 8'h02) ^ gf_mul(a3, 8'h03);
      o[8*(4*c+3) +: 8] = gf_mul(a0, 8'h03) ^ a1 ^ a2 ^ gf_mul(a3, 8'h02);
    end
    return o;
  endfunction

endpackage

// File: rtl/fpabs_round.sv
module fpabs_round
  import fpabs_pkg::*;
(
  input  blk_t st_i,
  input  blk_t key_i,
  output blk_t st_o
);

  blk_t subsh_w;
  blk_t mixed_w;

  assign subsh_w = sub_shift(st_i);
  assign mixed_w = mix_cols(subsh_w);
  assign st_o    = mixed_w ^ key_i;

endmodule

// File: rtl/fpabs_lane.sv
module fpabs_lane
  import fpabs_pkg::*;
#(
  parameter blk_t INIT_ST   = '0,
  parameter blk_t FIN_KEY_A = '0,
  parameter blk_t FIN_KEY_B = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic absorb_i,
  input  logic fin_i,
  input  logic fin_sel_i,
  input  blk_t word_i,
  output blk_t st_o
);

  blk_t st_q;
  blk_t key_w;
  blk_t nxt_w;

  always_comb begin
    if (fin_i) key_w = fin_sel_i ? FIN_KEY_B : FIN_KEY_A;
    else       key_w = word_i;
  end

  fpabs_round u_round (
    .st_i (st_q),
    .key_i(key_w),
    .st_o (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                st_q <= '0;
    else if (load_i)           st_q <= INIT_ST;
    else if (absorb_i || fin_i) st_q <= nxt_w;
  end

  assign st_o = st_q;

endmodule

// File: rtl/fpabs_ctrl.sv
module fpabs_ctrl
  import fpabs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  output logic             load_o,
  output logic             take_o,
  output logic             fin_o,
  output logic             fin_sel_o,
  output logic             ready_o,
  output logic             busy_o,
  output logic             done_o
);

  phase_t           ph_q;
  logic [LEN_W-1:0] left_q;
  logic             done_q;

  assign load_o    = start_i && (ph_q == PH_IDLE);
  assign ready_o   = (ph_q == PH_ABSORB);
  assign take_o    = ready_o && in_valid_i;
  assign fin_o     = (ph_q == PH_FIN_A) || (ph_q == PH_FIN_B);
  assign fin_sel_o = (ph_q == PH_FIN_B);
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (ph_q == PH_FIN_B);
      unique case (ph_q)
        PH_IDLE: begin
          if (load_o) begin
            left_q <= len_i;
            ph_q   <= (len_i == '0) ? PH_FIN_A : PH_ABSORB;
          end
        end
        PH_ABSORB: begin
          if (take_o) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) ph_q <= PH_FIN_A;
          end
        end
        PH_FIN_A: ph_q <= PH_FIN_B;
        PH_FIN_B: ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpabs_absorber.sv
module fpabs_absorber
  import fpabs_pkg::*;
#(
  parameter int                   LANES      = 4,
  parameter int                   LEN_W      = 16,
  parameter logic [LANES*128-1:0] INIT_STATE = {LANES{128'h243f6a88_85a308d3_13198a2e_03707344}},
  parameter blk_t                 FIN_KEY_A  = 128'ha4093822_299f31d0_082efa98_ec4e6c89,
  parameter blk_t                 FIN_KEY_B  = 128'h452821e6_38d01377_be5466cf_34e90c6c
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [LANES*BLK_W-1:0] in_data_i,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [LANES*BLK_W-1:0] fp_o
);

  localparam int FP_W = LANES * BLK_W;

  logic load_w;
  logic take_w;
  logic fin_w;
  logic fin_sel_w;
  logic fin_last_w;

  fpabs_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .len_i     (len_i),
    .in_valid_i(in_valid_i),
    .load_o    (load_w),
    .take_o    (take_w),
    .fin_o     (fin_w),
    .fin_sel_o (fin_sel_w),
    .ready_o   (in_ready_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign fin_last_w = fin_w && fin_sel_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fpabs_lane #(
      .INIT_ST  (INIT_STATE[k*BLK_W +: BLK_W]),
      .FIN_KEY_A(FIN_KEY_A),
      .FIN_KEY_B(FIN_KEY_B)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_w),
      .absorb_i (take_w),
      .fin_i    (fin_w),
      .fin_sel_i(fin_sel_w),
      .word_i   (in_data_i[k*BLK_W +: BLK_W]),
      .st_o     (fp_o[k*BLK_W +: BLK_W])
    );
  end

  if (FP_W != LANES * 128) begin : g_bad_width
    initial $error("lane width must be 128");
  end

endmodule

// File: rtl/fpabs_checker.sv
module fpabs_checker #(
  parameter int LEN_W = 16,
  parameter int FP_W  = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [FP_W-1:0]  fp_o,
  input logic             fin_last_w
);

  logic [LEN_W:0]   got_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_q <= '0;
      len_q <= '0;
    end else if (start_i && !busy_o) begin
      got_q <= '0;
      len_q <= len_i;
    end else if (in_valid_i && in_ready_o) begin
      got_q <= got_q + 1'b1;
    end
  end

  // R2: never ready while idle
  a_r2_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> busy_o);

  // R2 / R8: exactly the programmed number of words was taken
  a_r8_word_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (got_q == {1'b0, len_q}));

  // R5: completion follows the second finishing round
  a_r5_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(fin_last_w));

  // R6: single-cycle completion pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: result holds while idle
  a_r6_fp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(fp_o));

  // R7: zero-length job never asks for words
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && len_i == '0) |=> (busy_o && !in_ready_o));

endmodule

bind fpabs_absorber fpabs_checker #(
  .LEN_W(LEN_W),
  .FP_W (LANES*128)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .len_i     (len_i),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fp_o      (fp_o),
  .fin_last_w(fin_last_w)
);

// File: tb/test_fpabs_absorber.sv
module test_fpabs_absorber;

  localparam int LANES = 4;
  localparam int FPW   = LANES * 128;
  localparam logic [FPW-1:0] T_INIT =
    {128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, 128'h11223344_55667788_99aabbcc_ddeeff00,
     128'hdeadbeef_01234567_89abcdef_fedcba98, 128'h3141592a_2718281b_1414213c_1732050d};
  localparam logic [127:0] T_FKA = 128'h5a5a5a5a_00ff00ff_c0ffee00_12345678;
  localparam logic [127:0] T_FKB = 128'h0badf00d_cafebabe_76543210_a5a5c3c3;

  localparam int NV = 6;
  localparam int V_LEN  [NV] = '{1, 2, 3, 6, 12, 33};
  localparam int V_SEED [NV] = '{7, 19, 101, 5, 77, 2024};
  localparam int V_GAP  [NV] = '{0, 1, 0, 2, 1, 0};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [15:0]    len_i = '0;
  logic [FPW-1:0] in_data_i = '0;
  logic           in_valid_i = 1'b0;
  logic           in_ready_o, busy_o, done_o;
  logic [FPW-1:0] fp_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sb [256];

  always #2 clk = ~clk;

  fpabs_absorber #(
    .LANES(LANES), .LEN_W(16), .INIT_STATE(T_INIT), .FIN_KEY_A(T_FKA), .FIN_KEY_B(T_FKB)
  ) i_fpabs_absorber (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .busy_o(busy_o), .done_o(done_o), .fp_o(fp_o)
  );

  task automatic chk(input bit ok, input string req, input logic [FPW-1:0] act,
                     input logic [FPW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] a, input int n);
    return 8'((a << n) | (a >> (8 - n)));
  endfunction

  // S-box from a walk over powers of 3 and of its inverse
  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01;
    q = 8'h01;
    repeat (255) begin
      p = p ^ xt(p);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k);
    logic [7:0] a [16];
    logic [7:0] b [16];
    logic [7:0] t;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) a[i] = sb[s[8*i +: 8]];
    for (int i = 0; i < 16; i++) b[i] = a[(i % 4) + 4 * (((i / 4) + (i % 4)) % 4)];
    for (int c = 0; c < 4; c++) begin
      t = b[4*c] ^ b[4*c+1] ^ b[4*c+2] ^ b[4*c+3];
      o[8*(4*c)   +: 8] = b[4*c]   ^ t ^ xt(b[4*c]   ^ b[4*c+1]);
      o[8*(4*c+1) +: 8] = b[4*c+1] ^ t ^ xt(b[4*c+1] ^ b[4*c+2]);
      o[8*(4*c+2) +: 8] = b[4*c+2] ^ t ^ xt(b[4*c+2] ^ b[4*c+3]);
      o[8*(4*c+3) +: 8] = b[4*c+3] ^ t ^ xt(b[4*c+3] ^ b[4*c]);
    end
    return o ^ k;
  endfunction

  function automatic logic [FPW-1:0] gen(input int seed, input int idx, input bit flip);
    logic [FPW-1:0] w;
    logic [31:0] x;
    for (int j = 0; j < FPW / 32; j++) begin
      x = 32'(seed) * 32'h9e3779b1 + 32'(idx) * 32'h85ebca77 + 32'(j) * 32'hc2b2ae3d;
      x = x ^ (x >> 15);
      x = x * 32'h2c1b3c6d;
      x = x ^ (x >> 12);
      w[32*j +: 32] = x;
    end
    if (flip && idx == 0) w[256 +: 128] = w[256 +: 128] ^ 128'h1;
    return w;
  endfunction

  function automatic logic [FPW-1:0] model(input int n, input int seed, input bit flip);
    logic [FPW-1:0] st;
    logic [FPW-1:0] w;
    st = T_INIT;
    for (int i = 0; i < n; i++) begin
      w = gen(seed, i, flip);
      for (int k = 0; k < LANES; k++) st[128*k +: 128] = m_round(st[128*k +: 128], w[128*k +: 128]);
    end
    for (int k = 0; k < LANES; k++) st[128*k +: 128] = m_round(st[128*k +: 128], T_FKA);
    for (int k = 0; k < LANES; k++) st[128*k +: 128] = m_round(st[128*k +: 128], T_FKB);
    return st;
  endfunction

  task automatic start_job(input int n);
    @(negedge clk);
    start_i = 1'b1;
    len_i   = 16'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic feed(input int n, input int seed, input int gap, input bit flip,
                      input bit poke);
    int idx = 0;
    int cyc = 0;
    bit rdy;
    while (idx < n) begin
      in_valid_i = !(gap != 0 && (cyc % (gap + 1)) != 0);
      in_data_i  = in_valid_i ? gen(seed, idx, flip) : {FPW{1'b1}};
      start_i    = poke && cyc == 1;
      len_i      = poke ? 16'd7 : len_i;
      rdy        = in_ready_o;
      @(negedge clk);
      if (in_valid_i && rdy) idx++;
      cyc++;
    end
    in_valid_i = 1'b0;
    start_i    = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      if (done_o) begin
        lat = k;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_job(input int n, input int seed, input int gap, input bit flip,
                         input bit poke, output logic [FPW-1:0] res);
    int lat;
    logic [FPW-1:0] exp;
    logic [FPW-1:0] held;
    exp = model(n, seed, flip);
    start_job(n);
    if (n > 0) begin
      chk(in_ready_o === 1'b1, "R2 ready after start", FPW'(in_ready_o), FPW'(1));
      feed(n, seed, gap, flip, poke);
    end else begin
      chk(in_ready_o === 1'b0, "R7 no ready for zero length", FPW'(in_ready_o), FPW'(0));
    end
    wait_done(lat);
    chk(lat == 3, n > 0 ? "R5 done latency" : "R7 done latency", FPW'(lat), FPW'(3));
    chk(fp_o === exp, n == 0 ? "R7 fingerprint" : (gap != 0 ? "R4 fingerprint with gaps"
        : (poke ? "R8 fingerprint with stray start" : "R3 fingerprint")), fp_o, exp);
    held = fp_o;
    @(negedge clk);
    chk(done_o === 1'b0 && in_ready_o === 1'b0, "R6 done single cycle",
        FPW'({done_o, in_ready_o}), FPW'(0));
    repeat (3) @(negedge clk);
    chk(fp_o === held, "R6 fingerprint held", fp_o, held);
    res = held;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [FPW-1:0] ra, rb;
    build_sbox();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fp_o === '0 && done_o === 1'b0 && busy_o === 1'b0 && in_ready_o === 1'b0,
        "R1 during reset", fp_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fp_o === '0 && done_o === 1'b0 && busy_o === 1'b0 && in_ready_o === 1'b0,
        "R1 after reset", fp_o, '0);

    for (int v = 0; v < NV; v++) run_job(V_LEN[v], V_SEED[v], V_GAP[v], 1'b0, 1'b0, ra);

    // R7: zero-length job
    run_job(0, 0, 0, 1'b0, 1'b0, ra);

    // R4 / R2: words offered while idle are not taken and leave no trace
    in_valid_i = 1'b1;
    in_data_i  = gen(99, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk(in_ready_o === 1'b0, "R2 not ready while idle", FPW'(in_ready_o), FPW'(0));
    in_valid_i = 1'b0;
    run_job(4, 314, 0, 1'b0, 1'b0, ra);

    // R8: stray start while busy
    run_job(5, 42, 1, 1'b0, 1'b1, ra);

    // R9: one bit of lane 2's key slice touches lane 2 only
    run_job(3, 555, 0, 1'b0, 1'b0, ra);
    run_job(3, 555, 0, 1'b1, 1'b0, rb);
    chk(ra[0 +: 256] === rb[0 +: 256] && ra[384 +: 128] === rb[384 +: 128],
        "R9 other lanes unchanged", rb, ra);
    chk(ra[256 +: 128] !== rb[256 +: 128], "R9 lane 2 changed", rb, ra);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule